// File: doc/BRIEF.md
# Safe-Override System Clock Selector

This block picks one of several free-running clock sources (an internal RC oscillator, crystal oscillators, a PLL output) and drives it onto the system clock net. A mode controller supplies a binary source code, a per-source permission mask and a request to stop the system clock. A reset controller can raise a safe-clock request. That request wins over all three mode-controller inputs and forces the internal RC source.

Every change of source goes through a break-before-make handshake. The control state machine runs on the RC source, which never stops. It first withdraws the enable of the source that is running. That request crosses into the source's own domain through a synchronizer and is applied on a falling edge. The controller waits until the loss of the enable has been reported back before it raises the enable of the next source. A stop request uses the same withdrawal path, so the output settles low with no partial pulse. A status output reports the code of the source that is driving the output. It changes only once the new source's enable has been acknowledged.

Top module: `sys_clk_selector`

## Requirements
- R1: After reset, source code 0 (the internal RC source, `srcClk[0]`) drives `sysClk` and `activeSrc` reads 0.
- R2: When `safeReq` is low, `clkDisable` is low and `switchMask[selCode]` is 1, the selector moves to source `selCode` (binary index into `srcClk`). `activeSrc` then reads that code and `sysClk` runs at that source's rate.
- R3: A request for a source whose `switchMask` bit is 0 is ignored: `activeSrc` and `sysClk` keep the previous source.
- R4: While `safeReq` is high, source 0 is selected whatever the values of `selCode` and `switchMask`.
- R5: While `safeReq` is high, a change of `selCode` has no effect on `sysClk` or `activeSrc`.
- R6: When `safeReq` falls, the selector follows `selCode` again, subject to the mask.
- R7: When `clkDisable` is high and `safeReq` is low, `sysClk` is held low and `activeSrc` keeps the code of the last running source.
- R8: When `clkDisable` falls, the clock resumes on the selected source if its mask bit is set, and otherwise on the last running source.
- R9: A `safeReq` that arrives while the clock is disabled restarts `sysClk` on source 0.
- R10: During any switch, stop or restart, every high phase and every low phase of `sysClk` is at least half the period of the fastest source.
- R11: At no time is more than one source gate open.
- R12: `activeSrc` changes only to a code whose gate has been acknowledged back in the control domain.
- R13: A request for the source that is already active causes no change to the enable requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | NUM_SRC | Candidate clocks; bit 0 is the always-running internal RC source, which also clocks the controller |
| rstN | input | 1 | Asynchronous active-low reset |
| safeReq | input | 1 | Safe-clock request from the reset controller; forces source 0 |
| selCode | input | SEL_W | Requested source code from the mode controller |
| switchMask | input | NUM_SRC | Bit i set permits a switch to source i |
| clkDisable | input | 1 | Mode-controller request to stop the system clock |
| sysClk | output | 1 | Selected, glitch-free system clock |
| activeSrc | output | SEL_W | Code of the source that is currently driving sysClk |

## Verification
The bench builds the block with four sources and two-stage synchronizers. Each source runs at a different period (8, 10, 6 and 14 ns), so counting `sysClk` edges over a fixed window shows which source is driving the output. Including the fastest source makes the runt-pulse bound of R10 a tight limit. The scenario covers safe override on top of a stopped clock and a restart with a masked request.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int SCLK_NUM_SRC = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DROP  = 2'd1,
    ST_RAISE = 2'd2,
    ST_OFF   = 2'd3
  } selState_t;

  // strobes from control to datapath: one level request per source gate
  typedef struct packed {
    logic [SCLK_NUM_SRC-1:0] enReq;
  } gateCmd_t;
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
#(
  parameter int NUM_SRC = SCLK_NUM_SRC,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               rcClk,
  input  logic               rstN,
  input  logic               safeReq,
  input  logic [SEL_W-1:0]   selCode,
  input  logic [NUM_SRC-1:0] switchMask,
  input  logic               clkDisable,
  input  logic [NUM_SRC-1:0] ackOn,
  output gateCmd_t           gateCmd,
  output logic [SEL_W-1:0]   activeSrc,
  output logic               ctlIdle
);
  localparam logic [SEL_W-1:0] SAFE_CODE = '0;

  selState_t state;
  logic [SEL_W-1:0] curSrc;
  logic [SEL_W-1:0] tgtSrc;
  logic [NUM_SRC-1:0] reqReg;
  logic goingOff;

  logic [SEL_W-1:0] wantSrc;
  logic offWanted;
  logic wantAllowed;
  logic [SEL_W-1:0] resumeSrc;

  always_comb begin
    wantSrc   = safeReq ? SAFE_CODE : selCode;
    offWanted = clkDisable && !safeReq;
    if (safeReq) wantAllowed = 1'b1;
    else if (int'(selCode) >= NUM_SRC) wantAllowed = 1'b0;
    else wantAllowed = switchMask[selCode];
    resumeSrc = wantAllowed ? wantSrc : curSrc;
  end

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RAISE;
      curSrc   <= SAFE_CODE;
      tgtSrc   <= SAFE_CODE;
      reqReg   <= NUM_SRC'(1);
      goingOff <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (offWanted) begin
            reqReg[curSrc] <= 1'b0;
            goingOff       <= 1'b1;
            state          <= ST_DROP;
          end else if (wantAllowed && wantSrc != curSrc) begin
            reqReg[curSrc] <= 1'b0;
            tgtSrc         <= wantSrc;
            goingOff       <= 1'b0;
            state          <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (!ackOn[curSrc]) begin
            if (goingOff) begin
              state <= ST_OFF;
            end else begin
              reqReg[tgtSrc] <= 1'b1;
              state          <= ST_RAISE;
            end
          end
        end
        ST_RAISE: begin
          if (ackOn[tgtSrc]) begin
            curSrc <= tgtSrc;
            state  <= ST_IDLE;
          end
        end
        ST_OFF: begin
          if (!offWanted) begin
            tgtSrc            <= resumeSrc;
            reqReg[resumeSrc] <= 1'b1;
            goingOff          <= 1'b0;
            state             <= ST_RAISE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    gateCmd.enReq = reqReg;
    activeSrc     = curSrc;
    ctlIdle       = (state == ST_IDLE);
  end
endmodule

// File: rtl/sclk_gate_path.sv
module sclk_gate_path
  import sclk_pkg::*;
#(
  parameter int NUM_SRC     = SCLK_NUM_SRC,
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rcClk,
  input  logic               rstN,
  input  gateCmd_t           gateCmd,
  output logic [NUM_SRC-1:0] gateEn,
  output logic [NUM_SRC-1:0] ackOn,
  output logic               sysClk
);
  logic [NUM_SRC-1:0] gatedClk;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] fwdSync;
    logic [SYNC_STAGES-1:0] backSync;
    logic gateQ;

    // request into the source's own domain
    always_ff @(posedge srcClk[i] or negedge rstN) begin
      if (!rstN) fwdSync <= '0;
      else       fwdSync <= {fwdSync[SYNC_STAGES-2:0], gateCmd.enReq[i]};
    end

    // gate changes only while the source is low, so no partial high phase
    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) gateQ <= 1'b0;
      else       gateQ <= fwdSync[SYNC_STAGES-1];
    end

    // acknowledge back into the control domain
    always_ff @(posedge rcClk or negedge rstN) begin
      if (!rstN) backSync <= '0;
      else       backSync <= {backSync[SYNC_STAGES-2:0], gateQ};
    end

    always_comb begin
      gateEn[i]   = gateQ;
      ackOn[i]    = backSync[SYNC_STAGES-1];
      gatedClk[i] = srcClk[i] & gateQ;
    end
  end

  assign sysClk = |gatedClk;
endmodule

// File: rtl/sys_clk_selector.sv
module sys_clk_selector
  import sclk_pkg::*;
#(
  parameter int NUM_SRC     = SCLK_NUM_SRC,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  logic               safeReq,
  input  logic [SEL_W-1:0]   selCode,
  input  logic [NUM_SRC-1:0] switchMask,
  input  logic               clkDisable,
  output logic               sysClk,
  output logic [SEL_W-1:0]   activeSrc
);
  logic rcClk;
  gateCmd_t gateCmd;
  logic [NUM_SRC-1:0] enReq;
  logic [NUM_SRC-1:0] gateEn;
  logic [NUM_SRC-1:0] ackOn;
  logic ctlIdle;

  assign rcClk = srcClk[0];
  assign enReq = gateCmd.enReq;

  sclk_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .rcClk(rcClk), .rstN(rstN), .safeReq(safeReq), .selCode(selCode),
    .switchMask(switchMask), .clkDisable(clkDisable), .ackOn(ackOn),
    .gateCmd(gateCmd), .activeSrc(activeSrc), .ctlIdle(ctlIdle)
  );

  sclk_gate_path #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .srcClk(srcClk), .rcClk(rcClk), .rstN(rstN), .gateCmd(gateCmd),
    .gateEn(gateEn), .ackOn(ackOn), .sysClk(sysClk)
  );
endmodule

// File: rtl/sys_clk_selector_chk.sv
module sys_clk_selector_chk #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               rcClk,
  input logic               rstN,
  input logic               safeReq,
  input logic [SEL_W-1:0]   selCode,
  input logic [NUM_SRC-1:0] switchMask,
  input logic               clkDisable,
  input logic [SEL_W-1:0]   activeSrc,
  input logic [NUM_SRC-1:0] enReq,
  input logic [NUM_SRC-1:0] gateEn,
  input logic [NUM_SRC-1:0] ackOn,
  input logic               ctlIdle
);
  // R11: break-before-make across all gates
  assert_one_gate_R11: assert property (@(posedge rcClk) disable iff (!rstN)
    $onehot0(gateEn));

  // R12: status moves only onto an acknowledged source
  assert_status_acked_R12: assert property (@(posedge rcClk) disable iff (!rstN)
    (activeSrc != $past(activeSrc)) |-> ackOn[activeSrc]);

  // R4: a settled selector under safe request is on source 0 or leaving it
  assert_safe_forces_rc_R4: assert property (@(posedge rcClk) disable iff (!rstN)
    (safeReq && ctlIdle) |=> (!ctlIdle || activeSrc == '0));

  // R13: asking for the running source leaves the requests alone
  assert_same_src_quiet_R13: assert property (@(posedge rcClk) disable iff (!rstN)
    (ctlIdle && !clkDisable && !safeReq && selCode == activeSrc) |=> $stable(enReq));

  // R3: a masked request leaves requests and status alone
  assert_masked_ignored_R3: assert property (@(posedge rcClk) disable iff (!rstN)
    (ctlIdle && !clkDisable && !safeReq && !switchMask[selCode])
      |=> ($stable(enReq) && $stable(activeSrc)));
endmodule

bind sys_clk_selector sys_clk_selector_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .rcClk(rcClk), .rstN(rstN), .safeReq(safeReq), .selCode(selCode),
  .switchMask(switchMask), .clkDisable(clkDisable), .activeSrc(activeSrc),
  .enReq(enReq), .gateEn(gateEn), .ackOn(ackOn), .ctlIdle(ctlIdle)
);

// File: tb/sim_sys_clk_selector.sv
`timescale 1ns/1ps
module sim_sys_clk_selector;
  localparam int NSRC = 4;
  localparam int SW = 2;
  localparam real WINDOW = 400.0;

  logic clk0 = 0, clk1 = 0, clk2 = 0, clk3 = 0;
  always #4 clk0 = ~clk0;
  always #5 clk1 = ~clk1;
  always #3 clk2 = ~clk2;
  always #7 clk3 = ~clk3;

  logic rstN;
  logic safeReq;
  logic [SW-1:0] selCode;
  logic [NSRC-1:0] switchMask;
  logic clkDisable;
  logic sysClk;
  logic [SW-1:0] activeSrc;

  sys_clk_selector #(.NUM_SRC(NSRC), .SYNC_STAGES(2)) u0 (
    .srcClk({clk3, clk2, clk1, clk0}), .rstN(rstN), .safeReq(safeReq),
    .selCode(selCode), .switchMask(switchMask), .clkDisable(clkDisable),
    .sysClk(sysClk), .activeSrc(activeSrc)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int expSrc;
    int period;   // 0 means clock stopped
    string req;
  } expItem_t;

  expItem_t sbQ[$];
  int pushCnt = 0;
  int doneCnt = 0;

  int edgeCnt = 0;
  always @(posedge sysClk) edgeCnt++;

  realtime lastRise = -1.0, lastFall = -1.0;
  realtime minPulse = 1.0e9;
  always @(sysClk) begin
    if (sysClk) begin
      if (lastFall >= 0.0 && ($realtime - lastFall) < minPulse) minPulse = $realtime - lastFall;
      lastRise = $realtime;
    end else begin
      if (lastRise >= 0.0 && ($realtime - lastRise) < minPulse) minPulse = $realtime - lastRise;
      lastFall = $realtime;
    end
  end

  // driver: apply inputs, let the handshake settle, push expectation
  task automatic drive(input int sel, input int mask, input bit safe, input bit dis,
                       input int expSrc, input int period, input string req);
    expItem_t it;
    @(negedge clk0);
    selCode = SW'(sel);
    switchMask = NSRC'(mask);
    safeReq = safe;
    clkDisable = dis;
    #300;
    it.expSrc = expSrc;
    it.period = period;
    it.req = req;
    sbQ.push_back(it);
    pushCnt++;
    wait (doneCnt == pushCnt);
  endtask

  // monitor: pop expectation, measure sysClk rate and status
  initial begin
    forever begin
      expItem_t it;
      int startCnt, got, expEdges, diff;
      wait (sbQ.size() > 0);
      it = sbQ.pop_front();
      @(negedge clk0);
      startCnt = edgeCnt;
      #(WINDOW);
      got = edgeCnt - startCnt;
      expEdges = (it.period == 0) ? 0 : int'(WINDOW) / it.period;
      diff = got - expEdges;
      checks++;
      if (diff > 1 || diff < -1 || (it.period == 0 && (got != 0 || sysClk !== 1'b0))) begin
        errors++;
        $display("FAIL %s: sysClk edges %0d expected %0d", it.req, got, expEdges);
      end
      checks++;
      if (int'(activeSrc) != it.expSrc) begin
        errors++;
        $display("FAIL %s: activeSrc %0d expected %0d", it.req, activeSrc, it.expSrc);
      end
      doneCnt++;
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; safeReq = 0; selCode = 0; switchMask = '1; clkDisable = 0;
    #2;
    checks++;
    if (activeSrc !== '0) begin
      errors++;
      $display("FAIL R1: activeSrc in reset %0d expected 0", activeSrc);
    end
    #50 rstN = 1;
    drive(0, 4'hF, 0, 0, 0, 8,  "R1 reset source");
    drive(1, 4'hF, 0, 0, 1, 10, "R2 switch to 1");
    drive(2, 4'hF, 0, 0, 2, 6,  "R2 switch to 2");
    drive(3, 4'h7, 0, 0, 2, 6,  "R3 masked request");
    drive(2, 4'hF, 0, 0, 2, 6,  "R13 same source");
    drive(2, 4'hF, 1, 0, 0, 8,  "R4 safe override");
    drive(3, 4'h0, 1, 0, 0, 8,  "R5 select ignored in safe");
    drive(3, 4'hF, 0, 0, 3, 14, "R6 safe released");
    drive(3, 4'hF, 0, 1, 3, 0,  "R7 clock stopped");
    drive(3, 4'hF, 1, 1, 0, 8,  "R9 safe restarts");
    drive(3, 4'hF, 0, 1, 0, 0,  "R7 stopped again");
    drive(1, 4'h8, 0, 0, 0, 8,  "R8 resume masked keeps last");
    drive(3, 4'hF, 0, 0, 3, 14, "R2 switch to 3");
    drive(1, 4'h2, 0, 0, 1, 10, "R2 switch to 1 single mask");
    drive(1, 4'h2, 0, 1, 1, 0,  "R7 stop from 1");
    drive(2, 4'hF, 0, 0, 2, 6,  "R8 resume on selected");
    checks++;
    if (minPulse < 3.0) begin
      errors++;
      $display("FAIL R10: shortest sysClk phase %0.3f ns expected >= 3.000", minPulse);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule